// File: doc/BRIEF.md
# Register Bank with Broadcast Aliases

This block is a small memory-mapped register bank that answers a single-beat CPU request interface. A request carries a strobe, a write flag, a byte address, write data and byte enables. Exactly one cycle later the bank returns an acknowledge, an error flag and read data. Each of the four 32-bit registers has its own word address. Beyond those, the bank decodes extra alias addresses. An alias owns no storage. It only adds decode terms, so a single access reaches every register mapped to it in the same cycle.

The bank has three kinds of alias:

- **0x10** is a pair alias that reaches registers 0 and 2.
- **0x14** is a global alias that reaches all four registers.
- **0x18 and 0x1C** form a group window. Registers are viewed as two groups of two, one starting at register 0 and one starting at register 2. Window member k reaches register k of every group, so 0x18 selects registers 0 and 2 and 0x1C selects registers 1 and 3.

The registers do not all allow the same access:

- Register 1 is read-only. It reads back the `status_in` word and stores nothing.
- Register 3 is write-only.
- Registers 0 and 2 are read/write.

Each register only takes part in the kind of access it allows, and this holds through every alias that reaches it.

Top module: `bcast_regbank`

## Requirements
- R1: Reset (synchronous, active-low) clears every stored register, `rsp_ack`, `rsp_err` and `rsp_rdata` to zero; it also clears them when applied in the middle of operation.
- R2: A request is acknowledged with `rsp_ack` high in exactly the cycle after `req_valid`, and `rsp_ack` is low after any cycle without a request.
- R3: A write to a register's own address (register i at byte address 4*i) updates only the byte lanes whose enable is set, where `req_be[k]` covers data bits 8k+7..8k. A write with all enables clear changes nothing and is not an error.
- R4: A read of a register's own address returns its stored value. A read of address 0x04 returns `status_in` as sampled at the request edge.
- R5: A write to alias 0x10 stores the data into registers 0 and 2 in the same cycle and leaves registers 1 and 3 unchanged.
- R6: A write to alias 0x14 stores the data into every writable register (0, 2 and 3) in the same cycle. Register 1 stays read-only, and its slot on `reg_out` stays zero.
- R7: Group alias member k at address 0x18+4k selects register k of the group at register 0 and of the group at register 2. A write to 0x1C therefore updates only register 3, and a read of 0x1C returns only register 1's status.
- R8: A read at any alias returns the bitwise OR of the readback values of all readable registers it selects. Write-only registers contribute nothing to that OR.
- R9: An access of a kind a register does not allow (a write to 0x04 or a read of 0x0C) returns `rsp_err` high with read data zero and changes no register.
- R10: An access whose address matches no register and no alias, including unaligned addresses such as 0x02 and addresses such as 0x20, returns `rsp_err` high with read data zero and changes no register.
- R11: A write through an alias applies the same byte enables to every selected register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request strobe, one access per high cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte address of the access |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables for writes |
| status_in | input | 32 | Status word seen through read-only register 1 |
| rsp_rdata | output | 32 | Read data, valid with `rsp_ack` |
| rsp_ack | output | 1 | Access acknowledge, one cycle after the request |
| rsp_err | output | 1 | Access selected no register |
| reg_out | output | 128 | Stored register contents, register i at bits 32i+31..32i |

## Verification
A wrong select term is visible on `reg_out` in the cycle after the write that triggers it: a register outside an alias's reach changes, or a target stays behind. A wrong access qualification or readback gate shows up on the acknowledge of the same access. It appears either as an `rsp_err` that should not be there, or as read data that carries a write-only register's value. Because storage is only visible through reads and `reg_out`, every write vector is followed by a comparison of all four slots, so a fault stays hidden for at most one access.

// File: rtl/rbk_pkg.sv
// Package: shared constants for the broadcast register bank.
// Holds the register count, per-register access kinds and the alias maps.
// Assumes 32-bit words on a byte-addressed bus with 8-bit addresses.
package rbk_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;
    localparam int NREG   = 4;

    typedef enum logic [1:0] {
        ACC_RW = 2'd0,
        ACC_RO = 2'd1,
        ACC_WO = 2'd2
    } acc_e;

    // Access kind of every real register, index = register number.
    localparam acc_e REG_ACC [NREG] = '{ACC_RW, ACC_RO, ACC_RW, ACC_WO};

    // Plain aliases: address and the set of registers each one reaches.
    localparam int NBC = 2;
    localparam logic [7:0]      BC_ADDR [NBC] = '{8'h10, 8'h14};
    localparam logic [NREG-1:0] BC_MASK [NBC] = '{4'b0101, 4'b1111};

    // Group alias window: member k reaches register (first + k) of each group.
    localparam logic [7:0] GRP_BASE = 8'h18;
    localparam int GRP_LEN  = 2;
    localparam int NGRP_TGT = 2;
    localparam int GRP_FIRST [NGRP_TGT] = '{0, 2};

endpackage

// File: rtl/rbk_decode.sv
// Module: rbk_decode
// Turns one request into per-register read and write selects.
// A register is hit by its own address, by any plain alias whose mask
// includes it, or by a group alias member that maps onto it. Each hit is
// then qualified by the register's access kind. miss flags a request that
// selects nothing. Assumes word addresses are multiples of DATA_W/8.
module rbk_decode
    import rbk_pkg::*;
#(
    parameter int DATA_W = rbk_pkg::DATA_W,
    parameter int ADDR_W = rbk_pkg::ADDR_W
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    output logic [NREG-1:0]   wr_sel,
    output logic [NREG-1:0]   rd_sel,
    output logic              miss
);
    localparam int WORD_B = DATA_W / 8;

    logic [NREG-1:0] hit;
    logic [NREG-1:0] sel;

    // Purpose: OR together own-address, plain-alias and group-alias terms.
    always_comb begin
        hit = '0;
        for (int r = 0; r < NREG; r++) begin
            if (req_addr == ADDR_W'(r * WORD_B)) begin
                hit = hit | (NREG'(1) << r);
            end
        end
        for (int b = 0; b < NBC; b++) begin
            if (req_addr == ADDR_W'(BC_ADDR[b])) begin
                hit = hit | BC_MASK[b];
            end
        end
        for (int m = 0; m < GRP_LEN; m++) begin
            if (req_addr == ADDR_W'(int'(GRP_BASE) + m * WORD_B)) begin
                for (int g = 0; g < NGRP_TGT; g++) begin
                    hit = hit | (NREG'(1) << (GRP_FIRST[g] + m));
                end
            end
        end
    end

    // Qualify each register's hit by its access kind.
    for (genvar r = 0; r < NREG; r++) begin : g_qual
        if (REG_ACC[r] == ACC_RO) begin : g_ro
            assign sel[r] = req_valid & hit[r] & ~req_write;
        end else if (REG_ACC[r] == ACC_WO) begin : g_wo
            assign sel[r] = req_valid & hit[r] & req_write;
        end else begin : g_rw
            assign sel[r] = req_valid & hit[r];
        end
    end

    assign wr_sel = sel & {NREG{req_write}};
    assign rd_sel = sel & {NREG{~req_write}};
    assign miss   = req_valid & ~(|sel);

endmodule

// File: rtl/rbk_store.sv
// Module: rbk_store
// Holds the storage of every writable register and forms each register's
// readback source. Read-only registers store nothing and read back the
// status word. Write-only registers offer no readback. Byte lane k of a
// write lands only where be[k] is set.
module rbk_store
    import rbk_pkg::*;
#(
    parameter int DATA_W = rbk_pkg::DATA_W,
    localparam int STRB_W = DATA_W / 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NREG-1:0]        wr_sel,
    input  logic [DATA_W-1:0]      wdata,
    input  logic [STRB_W-1:0]      be,
    input  logic [DATA_W-1:0]      status_in,
    output logic [NREG*DATA_W-1:0] q,
    output logic [NREG*DATA_W-1:0] rb
);

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        if (REG_ACC[r] == ACC_RO) begin : g_ro
            assign q[r*DATA_W +: DATA_W]  = '0;
            assign rb[r*DATA_W +: DATA_W] = status_in;
        end else begin : g_st
            logic [DATA_W-1:0] q_r;

            // Purpose: byte-enabled update of one register, cleared on reset.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q_r <= '0;
                end else if (wr_sel[r]) begin
                    for (int k = 0; k < STRB_W; k++) begin
                        if (be[k]) begin
                            q_r[k*8 +: 8] <= wdata[k*8 +: 8];
                        end
                    end
                end
            end

            assign q[r*DATA_W +: DATA_W] = q_r;
            if (REG_ACC[r] == ACC_WO) begin : g_wo
                assign rb[r*DATA_W +: DATA_W] = '0;
            end else begin : g_rw
                assign rb[r*DATA_W +: DATA_W] = q_r;
            end
        end
    end

endmodule

// File: rtl/rbk_readback.sv
// Module: rbk_readback
// Combines the readback sources of all read-selected registers with OR,
// so that an alias read returns the union of its targets.
// Assumes rd_sel is already qualified by access kind.
module rbk_readback
    import rbk_pkg::*;
#(
    parameter int DATA_W = rbk_pkg::DATA_W
) (
    input  logic [NREG-1:0]        rd_sel,
    input  logic [NREG*DATA_W-1:0] rb,
    output logic [DATA_W-1:0]      rd_word
);

    // Purpose: OR of gated readback sources.
    always_comb begin
        rd_word = '0;
        for (int r = 0; r < NREG; r++) begin
            if (rd_sel[r]) begin
                rd_word = rd_word | rb[r*DATA_W +: DATA_W];
            end
        end
    end

endmodule

// File: rtl/bcast_regbank.sv
// Module: bcast_regbank (top)
// Register bank with plain and group broadcast aliases on a one-beat
// request interface. The response (ack, err, rdata) is registered and
// appears one cycle after the request. Writes take effect at that same edge.
// Assumes at most one request per cycle and no back-pressure.
module bcast_regbank
    import rbk_pkg::*;
#(
    parameter int DATA_W = rbk_pkg::DATA_W,
    parameter int ADDR_W = rbk_pkg::ADDR_W,
    localparam int STRB_W = DATA_W / 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic                   req_write,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [DATA_W-1:0]      req_wdata,
    input  logic [STRB_W-1:0]      req_be,
    input  logic [DATA_W-1:0]      status_in,
    output logic [DATA_W-1:0]      rsp_rdata,
    output logic                   rsp_ack,
    output logic                   rsp_err,
    output logic [NREG*DATA_W-1:0] reg_out
);

    logic [NREG-1:0]        wr_sel;
    logic [NREG-1:0]        rd_sel;
    logic                   miss;
    logic [NREG*DATA_W-1:0] rb;
    logic [DATA_W-1:0]      rd_word;

    rbk_decode #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_decode (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .wr_sel    (wr_sel),
        .rd_sel    (rd_sel),
        .miss      (miss)
    );

    rbk_store #(.DATA_W(DATA_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_sel    (wr_sel),
        .wdata     (req_wdata),
        .be        (req_be),
        .status_in (status_in),
        .q         (reg_out),
        .rb        (rb)
    );

    rbk_readback #(.DATA_W(DATA_W)) u_readback (
        .rd_sel  (rd_sel),
        .rb      (rb),
        .rd_word (rd_word)
    );

    // Purpose: register the response one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_ack   <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_ack   <= req_valid;
            rsp_err   <= miss;
            rsp_rdata <= rd_word;
        end
    end

endmodule

// File: rtl/bcast_regbank_chk.sv
// Module: bcast_regbank_chk
// Port-level protocol and alias checks, bound to bcast_regbank.
// Assumes the default alias map in rbk_pkg.
module bcast_regbank_chk
    import rbk_pkg::*;
#(
    parameter int DATA_W = rbk_pkg::DATA_W,
    parameter int ADDR_W = rbk_pkg::ADDR_W,
    localparam int STRB_W = DATA_W / 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   req_valid,
    input logic                   req_write,
    input logic [ADDR_W-1:0]      req_addr,
    input logic [DATA_W-1:0]      req_wdata,
    input logic [STRB_W-1:0]      req_be,
    input logic [DATA_W-1:0]      rsp_rdata,
    input logic                   rsp_ack,
    input logic                   rsp_err,
    input logic [NREG*DATA_W-1:0] reg_out
);

    assert_ack_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_ack);

    assert_no_stray_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_ack);

    assert_err_zero_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_ack && rsp_rdata == '0));

    assert_err_no_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> $stable(reg_out));

    assert_no_lane_no_change_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_be == '0) |=> $stable(reg_out));

    assert_pair_alias_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_addr == ADDR_W'(BC_ADDR[0]) && req_be == '1)
        |=> (reg_out[0*DATA_W +: DATA_W] == $past(req_wdata)
             && reg_out[2*DATA_W +: DATA_W] == $past(req_wdata)
             && $stable(reg_out[3*DATA_W +: DATA_W])));

    assert_global_alias_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_addr == ADDR_W'(BC_ADDR[1]) && req_be == '1)
        |=> (reg_out[0*DATA_W +: DATA_W] == $past(req_wdata)
             && reg_out[2*DATA_W +: DATA_W] == $past(req_wdata)
             && reg_out[3*DATA_W +: DATA_W] == $past(req_wdata)
             && reg_out[1*DATA_W +: DATA_W] == '0));

endmodule

bind bcast_regbank bcast_regbank_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_be    (req_be),
    .rsp_rdata (rsp_rdata),
    .rsp_ack   (rsp_ack),
    .rsp_err   (rsp_err),
    .reg_out   (reg_out)
);

// File: tb/test_bcast_regbank.sv
`timescale 1ns/1ps
// Bench for bcast_regbank: a vector table walked by one loop, then
// directed checks for idle acknowledge and reset during operation.
module test_bcast_regbank;

    typedef struct packed {
        logic         wr;
        logic [7:0]   addr;
        logic [31:0]  wdata;
        logic [3:0]   be;
        logic         err;
        logic [31:0]  rdata;
        logic [127:0] regs;   // {reg3, reg2, reg1, reg0}
    } vec_t;

    localparam logic [31:0] STATUS = 32'h0000_5A00;
    localparam int NVEC = 18;

    localparam vec_t VEC [NVEC] = '{
        '{1'b1, 8'h00, 32'h1111_1111, 4'hF, 1'b0, 32'h0,        128'h00000000_00000000_00000000_11111111}, // R3 direct write
        '{1'b0, 8'h00, 32'h0,         4'h0, 1'b0, 32'h1111_1111, 128'h00000000_00000000_00000000_11111111}, // R4 direct read
        '{1'b1, 8'h10, 32'h2222_0000, 4'hF, 1'b0, 32'h0,        128'h00000000_22220000_00000000_22220000}, // R5 pair alias
        '{1'b0, 8'h08, 32'h0,         4'h0, 1'b0, 32'h2222_0000, 128'h00000000_22220000_00000000_22220000}, // R4 R5 read target
        '{1'b0, 8'h0C, 32'h0,         4'h0, 1'b1, 32'h0,        128'h00000000_22220000_00000000_22220000}, // R9 read of write-only
        '{1'b1, 8'h14, 32'h0000_ABCD, 4'h3, 1'b0, 32'h0,        128'h0000ABCD_2222ABCD_00000000_2222ABCD}, // R6 R11 global alias
        '{1'b0, 8'h14, 32'h0,         4'h0, 1'b0, 32'h2222_FBCD, 128'h0000ABCD_2222ABCD_00000000_2222ABCD}, // R8 OR readback
        '{1'b1, 8'h04, 32'hFFFF_FFFF, 4'hF, 1'b1, 32'h0,        128'h0000ABCD_2222ABCD_00000000_2222ABCD}, // R9 write to read-only
        '{1'b0, 8'h04, 32'h0,         4'h0, 1'b0, STATUS,       128'h0000ABCD_2222ABCD_00000000_2222ABCD}, // R4 status read
        '{1'b1, 8'h1C, 32'h1234_5678, 4'hF, 1'b0, 32'h0,        128'h12345678_2222ABCD_00000000_2222ABCD}, // R7 group member 1 write
        '{1'b0, 8'h1C, 32'h0,         4'h0, 1'b0, STATUS,       128'h12345678_2222ABCD_00000000_2222ABCD}, // R7 R8 group member 1 read
        '{1'b1, 8'h18, 32'h00FF_0000, 4'h4, 1'b0, 32'h0,        128'h12345678_22FFABCD_00000000_22FFABCD}, // R7 R11 group member 0
        '{1'b1, 8'h20, 32'hDEAD_BEEF, 4'hF, 1'b1, 32'h0,        128'h12345678_22FFABCD_00000000_22FFABCD}, // R10 unmapped write
        '{1'b0, 8'h02, 32'h0,         4'h0, 1'b1, 32'h0,        128'h12345678_22FFABCD_00000000_22FFABCD}, // R10 unaligned read
        '{1'b1, 8'h08, 32'h0000_0000, 4'h8, 1'b0, 32'h0,        128'h12345678_00FFABCD_00000000_22FFABCD}, // R3 single lane
        '{1'b0, 8'h10, 32'h0,         4'h0, 1'b0, 32'h22FF_ABCD, 128'h12345678_00FFABCD_00000000_22FFABCD}, // R8 pair read
        '{1'b0, 8'h18, 32'h0,         4'h0, 1'b0, 32'h22FF_ABCD, 128'h12345678_00FFABCD_00000000_22FFABCD}, // R8 group read
        '{1'b1, 8'h14, 32'hFFFF_FFFF, 4'h0, 1'b0, 32'h0,        128'h12345678_00FFABCD_00000000_22FFABCD}  // R3 no enables
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_write = 1'b0;
    logic [7:0]   req_addr = '0;
    logic [31:0]  req_wdata = '0;
    logic [3:0]   req_be = '0;
    logic [31:0]  status_in = STATUS;
    logic [31:0]  rsp_rdata;
    logic         rsp_ack;
    logic         rsp_err;
    logic [127:0] reg_out;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    bcast_regbank i_bcast_regbank (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_be    (req_be),
        .status_in (status_in),
        .rsp_rdata (rsp_rdata),
        .rsp_ack   (rsp_ack),
        .rsp_err   (rsp_err),
        .reg_out   (reg_out)
    );

    task automatic chk(input string tag, input int idx, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s step %0d: actual=%0h expected=%0h", tag, idx, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (5000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL R2 watchdog expired: actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: outputs during reset
        repeat (3) @(negedge clk);
        chk("R1", -1, {95'b0, rsp_ack, rsp_err, rsp_rdata}, 128'h0);
        chk("R1", -1, reg_out, 128'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            req_valid = 1'b1;
            req_write = VEC[i].wr;
            req_addr  = VEC[i].addr;
            req_wdata = VEC[i].wdata;
            req_be    = VEC[i].be;
            @(negedge clk);
            req_valid = 1'b0;
            req_write = 1'b0;
            chk("R2", i, {127'b0, rsp_ack}, 128'h1);
            chk("R9/R10 err", i, {127'b0, rsp_err}, {127'b0, VEC[i].err});
            chk("R4/R8 rdata", i, {96'b0, rsp_rdata}, {96'b0, VEC[i].rdata});
            chk("R3/R5/R6/R7 regs", i, reg_out, VEC[i].regs);
        end

        // R2: idle cycle gives no acknowledge
        @(negedge clk);
        chk("R2", NVEC, {127'b0, rsp_ack}, 128'h0);

        // R4: read-only register tracks a changed status word
        status_in = 32'hC0DE_0001;
        req_valid = 1'b1;
        req_addr  = 8'h04;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R4", NVEC + 1, {96'b0, rsp_rdata}, {96'b0, 32'hC0DE_0001});

        // R1: reset in the middle of operation
        req_valid = 1'b1;
        req_write = 1'b0;
        req_addr  = 8'h00;
        rst_n = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R1", NVEC + 2, reg_out, 128'h0);
        chk("R1", NVEC + 2, {95'b0, rsp_ack, rsp_err, rsp_rdata}, 128'h0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule